// File: doc/BRIEF.md
# Polyphase Coefficient Loader

This block fills a polyphase filter coefficient store from a stream of 32-bit words. Each word carries two signed 16-bit taps. The even tap sits in bits 15:0 and the odd tap in bits 31:16. The store is split into banks. One bank holds the taps for one video component in one scaling direction, for every phase of a frame. The host first names the bank it wants to fill. It then streams the words one phase at a time: all the words of phase 0, then phase 1, and so on up to the configured phase capacity. Phases past the active phase count are filled with zero words. When the tap count is odd, the unused upper half of the last word in each phase is cleared.

The store has a single read/write port, and the vertical filter also needs it. A filter read takes the port away from the loader for that cycle, and the loader then holds off the stream. A second read path lets a register interface read back one 16-bit tap from the bank currently selected, chosen by phase and tap number.

Stream rules: a word is taken on a rising clock edge where `s_valid` and `s_ready` are both high. `s_ready` is low in three cases: in a cycle with a bank select, in a cycle with a filter read, and from the moment the bank is complete until the next bank select. The source must hold `s_data` stable while `s_valid` is high and `s_ready` is low.

Top module: `coef_loader`

## Requirements
- R1: After reset, `load_done`, `rb_data` and `vf_rd_data` are 0 and the write position is phase 0, word 0 of bank 0.
- R2: An accepted word is written unchanged into the store, so a later readback of tap 2k returns its bits 15:0 and tap 2k+1 returns its bits 31:16.
- R3: A bank select (`bank_we`) sets the bank, returns the write position to phase 0 word 0 and clears `load_done` on the next edge, even in the middle of a load.
- R4: The store address is {bank, phase, word} with widths 4, 3 and 2 bits. The word index counts from 0 to ceil(taps/2)-1 and then moves to the next phase.
- R5: When `cfg_taps` is odd, bits 31:16 of the last word of each phase are written as zero.
- R6: Words for phases at or above `cfg_phases` (and below `cfg_max_phases`) are written as all zero, whatever `s_data` holds.
- R7: `load_done` rises on the edge that takes the last word of phase `cfg_max_phases`-1 and stays high until the next bank select. While it is high, `s_ready` is 0 and nothing is written.
- R8: While `vf_rd_en` is high, `mem_addr` equals `vf_rd_addr`, no word is written, and `vf_rd_data` shows that store word one cycle later. Otherwise `vf_rd_data` holds its value.
- R9: `rb_data` shows, one cycle after `rb_phase` and `rb_tap` are applied, the 16-bit tap stored in the selected bank at that phase and tap.
- R10: `s_ready` is high only when there is no bank select, no filter read and `load_done` is low. `mem_we` is high exactly when a word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_we | input | 1 | Bank select strobe |
| bank_addr | input | 4 | Bank to fill |
| cfg_taps | input | 4 | Taps per phase, 1 to 8 |
| cfg_phases | input | 4 | Active phases, 1 to 8 |
| cfg_max_phases | input | 4 | Phases streamed per bank, at least cfg_phases |
| s_valid | input | 1 | Coefficient word valid |
| s_ready | output | 1 | Coefficient word ready |
| s_data | input | 32 | Two packed taps, even tap in the low half |
| load_done | output | 1 | Whole bank written |
| mem_we | output | 1 | Store write enable |
| mem_addr | output | 9 | Shared store port address |
| mem_wdata | output | 32 | Store write data |
| vf_rd_en | input | 1 | Vertical filter read request |
| vf_rd_addr | input | 9 | Vertical filter read address |
| vf_rd_data | output | 32 | Vertical filter read data |
| rb_phase | input | 3 | Readback phase |
| rb_tap | input | 3 | Readback tap |
| rb_data | output | 16 | Readback tap value |

## Verification
The store is filled using three tap and phase shapes. An even tap count with every phase active exercises plain packing and word ordering. An odd tap count with fewer active phases than streamed phases separates the upper-half clearing from the dummy-phase zeroing. A two-phase bank that is reselected partway through shows whether the write position really restarts. Gaps in valid, random filter reads that take the port, and words still offered after the bank is complete show whether back-pressure and acceptance are applied on the correct cycles. Full readback sweeps over all phases and taps then confirm both halves of every stored word.

// File: rtl/coef_pkg.sv
package coef_pkg;
  localparam int unsigned DEF_COEF_W     = 16;
  localparam int unsigned DEF_BANK_W     = 4;
  localparam int unsigned DEF_MAX_TAPS   = 8;
  localparam int unsigned DEF_MAX_PHASES = 8;

  typedef enum logic {
    OWN_LOADER = 1'b0,
    OWN_FILTER = 1'b1
  } port_owner_e;
endpackage

// File: rtl/coef_wr_ptr.sv
module coef_wr_ptr #(
  parameter int unsigned BANK_W = 4,
  parameter int unsigned PH_W   = 3,
  parameter int unsigned PAIR_W = 2,
  parameter int unsigned TAPC_W = 4,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_addr,
  input  logic              advance,
  input  logic [TAPC_W-1:0] cfg_taps,
  input  logic [CNT_W-1:0]  cfg_max_phases,
  output logic [BANK_W-1:0] bank,
  output logic [PH_W-1:0]   phase,
  output logic [PAIR_W-1:0] pair,
  output logic              pair_last,
  output logic              done
);
  logic [TAPC_W:0]   taps_p1;
  logic [TAPC_W-1:0] last_pair_idx;
  logic              phase_last;

  always_comb begin
    taps_p1       = {1'b0, cfg_taps} + (TAPC_W+1)'(1);
    last_pair_idx = taps_p1[TAPC_W:1] - TAPC_W'(1);
    pair_last     = (TAPC_W'(pair) == last_pair_idx);
    phase_last    = (CNT_W'(phase) == (cfg_max_phases - CNT_W'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank  <= '0;
      phase <= '0;
      pair  <= '0;
      done  <= 1'b0;
    end else if (bank_we) begin
      bank  <= bank_addr;
      phase <= '0;
      pair  <= '0;
      done  <= 1'b0;
    end else if (advance) begin
      if (pair_last) begin
        pair <= '0;
        if (phase_last) begin
          phase <= '0;
          done  <= 1'b1;
        end else begin
          phase <= phase + PH_W'(1);
        end
      end else begin
        pair <= pair + PAIR_W'(1);
      end
    end
  end
endmodule

// File: rtl/coef_word_shape.sv
module coef_word_shape #(
  parameter int unsigned COEF_W = 16,
  parameter int unsigned PH_W   = 3,
  parameter int unsigned CNT_W  = 4
) (
  input  logic [2*COEF_W-1:0] raw,
  input  logic [PH_W-1:0]     phase,
  input  logic                pair_last,
  input  logic                taps_odd,
  input  logic [CNT_W-1:0]    cfg_phases,
  output logic [2*COEF_W-1:0] shaped
);
  logic dummy_phase;

  always_comb begin
    dummy_phase = (CNT_W'(phase) >= cfg_phases);
    if (dummy_phase)
      shaped = '0;
    else if (taps_odd && pair_last)
      shaped = {{COEF_W{1'b0}}, raw[COEF_W-1:0]};
    else
      shaped = raw;
  end
endmodule

// File: rtl/coef_store.sv
module coef_store #(
  parameter int unsigned COEF_W = 16,
  parameter int unsigned ADDR_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                a_we,
  input  logic                a_re,
  input  logic [ADDR_W-1:0]   a_addr,
  input  logic [2*COEF_W-1:0] a_wdata,
  output logic [2*COEF_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0]   rb_addr,
  input  logic                rb_hi,
  output logic [COEF_W-1:0]   rb_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [2*COEF_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      rb_data <= '0;
    end else begin
      if (a_re) a_rdata <= mem[a_addr];
      rb_data <= rb_hi ? mem[rb_addr][2*COEF_W-1:COEF_W] : mem[rb_addr][COEF_W-1:0];
    end
  end
endmodule

// File: rtl/coef_loader.sv
module coef_loader #(
  parameter int unsigned COEF_W     = coef_pkg::DEF_COEF_W,
  parameter int unsigned BANK_W     = coef_pkg::DEF_BANK_W,
  parameter int unsigned MAX_TAPS   = coef_pkg::DEF_MAX_TAPS,
  parameter int unsigned MAX_PHASES = coef_pkg::DEF_MAX_PHASES,
  localparam int unsigned WORD_W = 2 * COEF_W,
  localparam int unsigned TAP_W  = $clog2(MAX_TAPS),
  localparam int unsigned PAIR_W = $clog2(MAX_TAPS / 2),
  localparam int unsigned PH_W   = $clog2(MAX_PHASES),
  localparam int unsigned TAPC_W = $clog2(MAX_TAPS + 1),
  localparam int unsigned CNT_W  = $clog2(MAX_PHASES + 1),
  localparam int unsigned ADDR_W = BANK_W + PH_W + PAIR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_we,
  input  logic [BANK_W-1:0] bank_addr,
  input  logic [TAPC_W-1:0] cfg_taps,
  input  logic [CNT_W-1:0]  cfg_phases,
  input  logic [CNT_W-1:0]  cfg_max_phases,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WORD_W-1:0] s_data,
  output logic              load_done,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              vf_rd_en,
  input  logic [ADDR_W-1:0] vf_rd_addr,
  output logic [WORD_W-1:0] vf_rd_data,
  input  logic [PH_W-1:0]   rb_phase,
  input  logic [TAP_W-1:0]  rb_tap,
  output logic [COEF_W-1:0] rb_data
);
  import coef_pkg::*;

  logic [BANK_W-1:0] cur_bank;
  logic [PH_W-1:0]   cur_phase;
  logic [PAIR_W-1:0] cur_pair;
  logic              cur_pair_last;
  logic              accept;
  port_owner_e       owner;

  always_comb begin
    owner   = vf_rd_en ? OWN_FILTER : OWN_LOADER;
    s_ready = !bank_we && (owner == OWN_LOADER) && !load_done;
    accept  = s_valid && s_ready;
    mem_we  = accept;
    case (owner)
      OWN_FILTER: mem_addr = vf_rd_addr;
      default:    mem_addr = {cur_bank, cur_phase, cur_pair};
    endcase
  end

  coef_wr_ptr #(
    .BANK_W(BANK_W), .PH_W(PH_W), .PAIR_W(PAIR_W), .TAPC_W(TAPC_W), .CNT_W(CNT_W)
  ) u_ptr (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_addr(bank_addr),
    .advance(accept), .cfg_taps(cfg_taps), .cfg_max_phases(cfg_max_phases),
    .bank(cur_bank), .phase(cur_phase), .pair(cur_pair),
    .pair_last(cur_pair_last), .done(load_done)
  );

  coef_word_shape #(
    .COEF_W(COEF_W), .PH_W(PH_W), .CNT_W(CNT_W)
  ) u_shape (
    .raw(s_data), .phase(cur_phase), .pair_last(cur_pair_last),
    .taps_odd(cfg_taps[0]), .cfg_phases(cfg_phases), .shaped(mem_wdata)
  );

  coef_store #(
    .COEF_W(COEF_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .a_we(mem_we), .a_re(vf_rd_en),
    .a_addr(mem_addr), .a_wdata(mem_wdata), .a_rdata(vf_rd_data),
    .rb_addr({cur_bank, rb_phase, rb_tap[TAP_W-1:1]}), .rb_hi(rb_tap[0]),
    .rb_data(rb_data)
  );
endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk #(
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bank_we,
  input logic              s_ready,
  input logic              load_done,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              vf_rd_en,
  input logic [ADDR_W-1:0] vf_rd_addr
);
  // R3
  bank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |=> !load_done);

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && !bank_we) |=> load_done);

  // R7
  done_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (!mem_we && !s_ready));

  // R8
  filter_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vf_rd_en |-> (!mem_we && mem_addr == vf_rd_addr));

  // R10
  select_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_we |-> !mem_we);
endmodule

bind coef_loader coef_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .s_ready(s_ready),
  .load_done(load_done), .mem_we(mem_we), .mem_addr(mem_addr),
  .vf_rd_en(vf_rd_en), .vf_rd_addr(vf_rd_addr)
);

// File: tb/coef_loader_tb_top.sv
module coef_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_we = 1'b0;
  logic [3:0]  bank_addr = '0;
  logic [3:0]  cfg_taps = 4'd8;
  logic [3:0]  cfg_phases = 4'd8;
  logic [3:0]  cfg_max_phases = 4'd8;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = '0;
  logic        load_done;
  logic        mem_we;
  logic [8:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic        vf_rd_en = 1'b0;
  logic [8:0]  vf_rd_addr = '0;
  logic [31:0] vf_rd_data;
  logic [2:0]  rb_phase = '0;
  logic [2:0]  rb_tap = '0;
  logic [15:0] rb_data;

  always #4 clk = ~clk;

  coef_loader dut_i (
    .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .bank_addr(bank_addr),
    .cfg_taps(cfg_taps), .cfg_phases(cfg_phases), .cfg_max_phases(cfg_max_phases),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .load_done(load_done),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .vf_rd_en(vf_rd_en), .vf_rd_addr(vf_rd_addr), .vf_rd_data(vf_rd_data),
    .rb_phase(rb_phase), .rb_tap(rb_tap), .rb_data(rb_data)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // reference model state
  int          m_bank, m_phase, m_pair;
  bit          m_done;
  logic [31:0] m_mem [512];
  bit          m_wr [512];
  logic [15:0] e_rb;
  bit          e_rb_known;
  logic [31:0] e_vf;
  bit          e_vf_known;
  bit          just_banked;

  function automatic int addr_of(int b, int p, int w);
    return b * 32 + p * 4 + w;
  endfunction

  function automatic int words_per_phase();
    return (int'(cfg_taps) + 1) / 2;
  endfunction

  function automatic bit exp_ready();
    return !bank_we && !vf_rd_en && !m_done;
  endfunction

  function automatic logic [31:0] exp_word();
    if (m_phase >= int'(cfg_phases)) return 32'h0;
    if (cfg_taps[0] && m_pair == words_per_phase() - 1) return {16'h0, s_data[15:0]};
    return s_data;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      m_mem[i] = '0;
      m_wr[i] = 1'b0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bank = 0; m_phase = 0; m_pair = 0; m_done = 1'b0;
      e_rb = '0; e_rb_known = 1'b1; e_vf = '0; e_vf_known = 1'b1;
      just_banked = 1'b0;
    end else begin
      int ra;
      bit acc;
      ra = addr_of(m_bank, int'(rb_phase), int'(rb_tap) / 2);
      e_rb_known = m_wr[ra];
      e_rb = rb_tap[0] ? m_mem[ra][31:16] : m_mem[ra][15:0];
      if (vf_rd_en) begin
        e_vf_known = m_wr[vf_rd_addr];
        e_vf = m_mem[vf_rd_addr];
      end
      acc = s_valid && exp_ready();
      just_banked = 1'b0;
      if (bank_we) begin
        m_bank = int'(bank_addr); m_phase = 0; m_pair = 0; m_done = 1'b0;
        just_banked = 1'b1;
      end else if (acc) begin
        int wa;
        wa = addr_of(m_bank, m_phase, m_pair);
        m_mem[wa] = exp_word();
        m_wr[wa] = 1'b1;
        if (m_pair == words_per_phase() - 1) begin
          m_pair = 0;
          if (m_phase == int'(cfg_max_phases) - 1) begin
            m_phase = 0;
            m_done = 1'b1;
          end else m_phase++;
        end else m_pair++;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        chk("R1", "load_done", 32'(load_done), 32'(0));
        chk("R1", "rb_data", 32'(rb_data), 32'(0));
        chk("R1", "vf_rd_data", vf_rd_data, 32'(0));
      end else begin
        logic [31:0] ea;
        bit ewe;
        ewe = s_valid && exp_ready();
        chk("R10", "s_ready", 32'(s_ready), 32'(exp_ready()));
        chk("R10", "mem_we", 32'(mem_we), 32'(ewe));
        chk("R7", "load_done", 32'(load_done), 32'(m_done));
        ea = vf_rd_en ? 32'(vf_rd_addr) : 32'(addr_of(m_bank, m_phase, m_pair));
        chk(vf_rd_en ? "R8" : (just_banked ? "R3" : "R4"), "mem_addr", 32'(mem_addr), ea);
        if (ewe)
          chk((m_phase >= int'(cfg_phases)) ? "R6" :
              ((cfg_taps[0] && m_pair == words_per_phase() - 1) ? "R5" : "R2"),
              "mem_wdata", mem_wdata, exp_word());
        if (e_rb_known) chk("R9", "rb_data", 32'(rb_data), 32'(e_rb));
        if (e_vf_known) chk("R8", "vf_rd_data", vf_rd_data, e_vf);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic select_bank(input int b, input int taps, input int ph, input int maxph);
    step();
    bank_we = 1'b1; bank_addr = 4'(b); s_valid = 1'b0; vf_rd_en = 1'b0;
    cfg_taps = 4'(taps); cfg_phases = 4'(ph); cfg_max_phases = 4'(maxph);
    step();
    bank_we = 1'b0;
  endtask

  task automatic stream(input int n);
    int sent = 0;
    while (sent < n) begin
      step();
      s_valid = ($urandom % 4) != 0;
      s_data = $urandom;
      vf_rd_en = ($urandom % 5) == 0;
      vf_rd_addr = 9'($urandom % 512);
      rb_phase = 3'($urandom % 8);
      rb_tap = 3'($urandom % 8);
      #1;
      if (s_valid && s_ready) sent++;
    end
    step();
    s_valid = 1'b0; vf_rd_en = 1'b0;
  endtask

  task automatic rb_sweep();
    for (int p = 0; p < 8; p++)
      for (int t = 0; t < 8; t++) begin
        step();
        s_valid = 1'b0; vf_rd_en = 1'b0;
        rb_phase = 3'(p); rb_tap = 3'(t);
      end
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) step();
    rst_n = 1'b1;
    // R2 R4: even taps, all phases active
    select_bank(3, 8, 8, 8);
    stream(32);
    // R7: words offered after completion are refused
    for (int i = 0; i < 4; i++) begin
      step();
      s_valid = 1'b1; s_data = $urandom;
    end
    step();
    s_valid = 1'b0;
    // R5 R6: odd taps, dummy phases
    select_bank(5, 5, 3, 6);
    stream(18);
    rb_sweep();
    // R3: restart in the middle of a load
    select_bank(7, 3, 2, 2);
    stream(2);
    select_bank(7, 3, 2, 2);
    stream(4);
    rb_sweep();
    // R9: readback of earlier banks
    select_bank(5, 5, 3, 6);
    rb_sweep();
    select_bank(3, 8, 8, 8);
    rb_sweep();
    // R8: filter reads over bank 3
    for (int i = 0; i < 32; i++) begin
      step();
      vf_rd_en = 1'b1; vf_rd_addr = 9'(3 * 32 + i);
    end
    step();
    vf_rd_en = 1'b0;
    repeat (3) step();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule